// File: doc/BRIEF.md
# Bus Transfer Profiling Counter Bank

This block sits passively beside one AHB layer and keeps a bank of event counters for statistical profiling. It counts completed reads and writes, bursts by burst type, wait states in total, first-beat wait states split by cause (slave or interconnect), and wait runs that exceed a programmable threshold. It also keeps a free-running cycle counter, an enabled-cycle counter, and an enabled-cycle counter that skips debug cycles.

The bus signals are captured in a register stage before any event is decoded. Software controls the bank through a small word-aligned register port: it can enable counting, freeze counting during debug, clear or preset the bank, and read every counter back. Control writes are delayed to line up with the capture stage, so each bus cycle is counted under the configuration that was in force when the cycle happened.

Top module: `ahb_prof_bank`

## Requirements
- R1: After synchronous reset, every counter, the control register (byte 0x50: bit0 enable, bit1 debug freeze) and the threshold register (byte 0x54) read as zero.
- R2: The read counter (0x00) and write counter (0x04) step once per beat whose data phase ends with HREADY high and HRESP OKAY (00) or ERROR (01). A beat that ends with RETRY (10) or SPLIT (11) is not counted. HTRANS codes: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11.
- R3: Each burst is counted once, when its NONSEQ beat completes under the rule of R2, in the counter at byte address 0x08 + 4 x HBURST (HBURST 0..7).
- R4: The wait counter (0x28) steps once per data-phase cycle with HREADY low and HRESP OKAY.
- R5: On a NONSEQ beat, a wait cycle with the interconnect-stall input high steps the interconnect counter (0x30); one with it low and the slave select high steps the slave counter (0x2C).
- R6: The threshold counter (0x34) steps once per wait run, in the cycle where the run length first exceeds the threshold register.
- R7: With the enable bit low, the event counters and the no-debug cycle counter (0x40) hold; the enabled-cycle counter (0x3C) steps every cycle the enable bit is high. With the freeze bit set, a cycle with debug acknowledge high is not counted by the event counters or the no-debug counter.
- R8: The total cycle counter (0x38) steps every cycle and only hardware reset clears it.
- R9: Any write to byte 0x58 clears every counter except the total; events of the bus cycle carrying that write are dropped and those of the next cycle are counted.
- R10: Any write to byte 0x5C loads every counter except the total with its own byte address.
- R11: An event in bus cycle c appears in reads issued from cycle c+2. The read data, valid the cycle after the address, is the register value at the start of the address cycle; undecoded addresses read zero.
- R12: Counters wrap from all ones to zero without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| htrans | input | 2 | Monitored transfer type |
| hwrite | input | 1 | Monitored direction, high for write |
| hburst | input | 3 | Monitored burst type |
| hready | input | 1 | Monitored ready |
| hresp | input | 2 | Monitored response |
| hsel | input | 1 | Slave reached during the data phase |
| ic_stall | input | 1 | Interconnect holding the master off |
| dbg_ack | input | 1 | Debug acknowledge |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The assertions take for granted that clear and preset writes never land in back-to-back cycles on the same counter, and that the monitored bus keeps AHB pipelining: an address phase is accepted only on HREADY high and a non-OKAY response spans two cycles. The stimulus issues bursts through one task that builds the address and data phases from per-beat wait counts and a final response, with IDLE cycles between bursts, and issues register writes one at a time, so both assumptions hold.

// File: rtl/ahb_prof_pkg.sv
package ahb_prof_pkg;
  localparam int NCNT      = 17;
  localparam int IX_RD     = 0;
  localparam int IX_WR     = 1;
  localparam int IX_BST0   = 2;
  localparam int NBURST    = 8;
  localparam int IX_WAIT   = 10;
  localparam int IX_NS_SLV = 11;
  localparam int IX_NS_BUS = 12;
  localparam int IX_THR    = 13;
  localparam int IX_CYC    = 14;
  localparam int IX_CYC_EN = 15;
  localparam int IX_CYC_ND = 16;

  localparam int RG_CTRL = 20;
  localparam int RG_THR  = 21;
  localparam int RG_CLR  = 22;
  localparam int RG_PRE  = 23;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [NBURST-1:0] burst;
    logic              waitc;
    logic              ns_slv;
    logic              ns_bus;
  } ev_t;
endpackage

// File: rtl/ahb_prof_capture.sv
module ahb_prof_capture
  import ahb_prof_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] htrans,
  input  logic       hwrite,
  input  logic [2:0] hburst,
  input  logic       hready,
  input  logic [1:0] hresp,
  input  logic       hsel,
  input  logic       ic_stall,
  input  logic       dbg_ack,
  output ev_t        ev,
  output logic       dbg_q
);
  logic [1:0] t_q;
  logic       w_q;
  logic [2:0] b_q;
  logic       rdy_q;
  logic [1:0] resp_q;
  logic       sel_q;
  logic       ic_q;

  logic       dp_vld;
  logic       dp_wr;
  logic       dp_first;
  logic [2:0] dp_bst;

  // capture stage: isolates the bus from the counting logic
  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= TR_IDLE;
      w_q    <= 1'b0;
      b_q    <= '0;
      rdy_q  <= 1'b1;
      resp_q <= RSP_OKAY;
      sel_q  <= 1'b0;
      ic_q   <= 1'b0;
      dbg_q  <= 1'b0;
    end else begin
      t_q    <= htrans;
      w_q    <= hwrite;
      b_q    <= hburst;
      rdy_q  <= hready;
      resp_q <= hresp;
      sel_q  <= hsel;
      ic_q   <= ic_stall;
      dbg_q  <= dbg_ack;
    end
  end

  // data-phase tracking on the captured signals
  always_ff @(posedge clk) begin
    if (rst) begin
      dp_vld   <= 1'b0;
      dp_wr    <= 1'b0;
      dp_first <= 1'b0;
      dp_bst   <= '0;
    end else if (rdy_q) begin
      dp_vld   <= t_q[1];
      dp_wr    <= w_q;
      dp_first <= (t_q == TR_NONSEQ);
      dp_bst   <= b_q;
    end
  end

  logic resp_cnt;
  logic done;
  assign resp_cnt = (resp_q == RSP_OKAY) || (resp_q == RSP_ERROR);
  assign done     = dp_vld && rdy_q && resp_cnt;

  always_comb begin
    ev        = '0;
    ev.rd     = done && !dp_wr;
    ev.wr     = done && dp_wr;
    ev.waitc  = dp_vld && !rdy_q && (resp_q == RSP_OKAY);
    ev.ns_bus = ev.waitc && dp_first && ic_q;
    ev.ns_slv = ev.waitc && dp_first && !ic_q && sel_q;
    for (int k = 0; k < NBURST; k++)
      ev.burst[k] = done && dp_first && (dp_bst == 3'(k));
  end
endmodule

// File: rtl/ahb_prof_waitrun.sv
module ahb_prof_waitrun #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wait_cyc,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  localparam int RUN_W = THR_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)
      run_q <= '0;
    else if (!wait_cyc)
      run_q <= '0;
    else if (run_q != RUN_MAX)
      run_q <= run_q + 1'b1;
  end

  // this wait makes the run one longer than the threshold
  assign hit = wait_cyc && (run_q == {1'b0, thr});
endmodule

// File: rtl/ahb_prof_cnt.sv
module ahb_prof_cnt #(
  parameter int CNT_W  = 32,
  parameter int PRESET = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             pre,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  localparam logic [CNT_W-1:0] PV = CNT_W'(PRESET);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else if (pre) q <= PV;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/ahb_prof_bank.sv
module ahb_prof_bank
  import ahb_prof_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int THR_W  = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hburst,
  input  logic              hready,
  input  logic [1:0]        hresp,
  input  logic              hsel,
  input  logic              ic_stall,
  input  logic              dbg_ack,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int WI_W = ADDR_W - 2;

  ev_t  ev;
  logic dbg_q;
  logic thr_hit;

  logic             ctrl_en, ctrl_trk, ctrl_en_d, ctrl_trk_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             clr_pend, pre_pend;
  logic             cnt_active;

  logic [NCNT-1:0]            inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt_q;

  logic [WI_W-1:0] widx;
  logic wr_ctrl, wr_thr, wr_clr, wr_pre;
  logic wdata_unused;

  assign widx    = reg_addr[ADDR_W-1:2];
  assign wr_ctrl = reg_wen && (widx == WI_W'(RG_CTRL));
  assign wr_thr  = reg_wen && (widx == WI_W'(RG_THR));
  assign wr_clr  = reg_wen && (widx == WI_W'(RG_CLR));
  assign wr_pre  = reg_wen && (widx == WI_W'(RG_PRE));
  assign wdata_unused = ^{reg_wdata[31:THR_W], reg_addr[1:0]};

  ahb_prof_capture cap_i (
    .clk(clk), .rst(rst), .htrans(htrans), .hwrite(hwrite), .hburst(hburst),
    .hready(hready), .hresp(hresp), .hsel(hsel), .ic_stall(ic_stall),
    .dbg_ack(dbg_ack), .ev(ev), .dbg_q(dbg_q)
  );

  ahb_prof_waitrun #(.THR_W(THR_W)) run_i (
    .clk(clk), .rst(rst), .wait_cyc(ev.waitc), .thr(thr_d), .hit(thr_hit)
  );

  // control registers, plus copies delayed to match the capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_trk   <= 1'b0;
      thr_q      <= '0;
      ctrl_en_d  <= 1'b0;
      ctrl_trk_d <= 1'b0;
      thr_d      <= '0;
      clr_pend   <= 1'b0;
      pre_pend   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= reg_wdata[0];
        ctrl_trk <= reg_wdata[1];
      end
      if (wr_thr) thr_q <= reg_wdata[THR_W-1:0];
      ctrl_en_d  <= ctrl_en;
      ctrl_trk_d <= ctrl_trk;
      thr_d      <= thr_q;
      clr_pend   <= wr_clr;
      pre_pend   <= wr_pre;
    end
  end

  assign cnt_active = ctrl_en_d && !(ctrl_trk_d && dbg_q);

  always_comb begin
    inc            = '0;
    inc[IX_RD]     = cnt_active && ev.rd;
    inc[IX_WR]     = cnt_active && ev.wr;
    for (int k = 0; k < NBURST; k++)
      inc[IX_BST0+k] = cnt_active && ev.burst[k];
    inc[IX_WAIT]   = cnt_active && ev.waitc;
    inc[IX_NS_SLV] = cnt_active && ev.ns_slv;
    inc[IX_NS_BUS] = cnt_active && ev.ns_bus;
    inc[IX_THR]    = cnt_active && thr_hit;
    inc[IX_CYC]    = 1'b1;
    inc[IX_CYC_EN] = ctrl_en_d;
    inc[IX_CYC_ND] = cnt_active;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    if (g == IX_CYC) begin : g_free
      ahb_prof_cnt #(.CNT_W(CNT_W), .PRESET(0)) cnt_i (
        .clk(clk), .rst(rst), .clr(1'b0), .pre(1'b0), .inc(inc[g]), .q(cnt_q[g])
      );
    end else begin : g_ctl
      ahb_prof_cnt #(.CNT_W(CNT_W), .PRESET(g * 4)) cnt_i (
        .clk(clk), .rst(rst), .clr(clr_pend), .pre(pre_pend), .inc(inc[g]), .q(cnt_q[g])
      );
    end
  end

  logic [31:0] rd_n;
  always_comb begin
    rd_n = '0;
    for (int i = 0; i < NCNT; i++)
      if (widx == WI_W'(i)) rd_n[CNT_W-1:0] = cnt_q[i];
    if (widx == WI_W'(RG_CTRL)) rd_n[1:0] = {ctrl_trk, ctrl_en};
    if (widx == WI_W'(RG_THR))  rd_n[THR_W-1:0] = thr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end
endmodule

// File: rtl/ahb_prof_chk.sv
module ahb_prof_chk
  import ahb_prof_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NCNT-1:0][CNT_W-1:0] cnt,
  input logic                       clr_pend,
  input logic                       pre_pend,
  input logic                       act,
  input logic                       en_d
);
  // R8
  total_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt[IX_CYC] == CNT_W'($past(cnt[IX_CYC]) + 1'b1));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pend |=> (cnt[IX_RD] == '0) && (cnt[IX_WAIT] == '0) && (cnt[IX_CYC_EN] == '0));

  // R10
  preset_load_chk: assert property (@(posedge clk) disable iff (rst)
    pre_pend && !clr_pend |=> cnt[IX_WAIT] == CNT_W'(IX_WAIT * 4));

  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !act && !clr_pend && !pre_pend |=> $stable(cnt[IX_WAIT]) && $stable(cnt[IX_RD]) && $stable(cnt[IX_CYC_ND]));

  // R7
  en_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_d && !clr_pend && !pre_pend |=> $stable(cnt[IX_CYC_EN]));

  // R4
  wait_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_pend && !pre_pend |=>
      (cnt[IX_WAIT] == $past(cnt[IX_WAIT])) || (cnt[IX_WAIT] == CNT_W'($past(cnt[IX_WAIT]) + 1'b1)));
endmodule

bind ahb_prof_bank ahb_prof_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cnt(cnt_q), .clr_pend(clr_pend), .pre_pend(pre_pend),
  .act(cnt_active), .en_d(ctrl_en_d)
);

// File: tb/ahb_prof_bank_tb_top.sv
module ahb_prof_bank_tb_top;
  localparam int CLK_P  = 10;
  localparam int WD_CYC = 20000;
  localparam int NM     = 17;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] htrans = 2'b00;
  logic       hwrite = 1'b0;
  logic [2:0] hburst = 3'd0;
  logic       hready = 1'b1;
  logic [1:0] hresp = 2'b00;
  logic       hsel = 1'b1;
  logic       ic_stall = 1'b0;
  logic       dbg_ack = 1'b0;
  logic       reg_wen = 1'b0;
  logic [6:0] reg_addr = 7'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] rdata_w, rdata_n;

  ahb_prof_bank dut_i (
    .clk(clk), .rst(rst), .htrans(htrans), .hwrite(hwrite), .hburst(hburst),
    .hready(hready), .hresp(hresp), .hsel(hsel), .ic_stall(ic_stall), .dbg_ack(dbg_ack),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_w)
  );

  // narrow copy, fed identically, to reach counter wrap (R12)
  ahb_prof_bank #(.CNT_W(8)) dut_n (
    .clk(clk), .rst(rst), .htrans(htrans), .hwrite(hwrite), .hburst(hburst),
    .hready(hready), .hresp(hresp), .hsel(hsel), .ic_stall(ic_stall), .dbg_ack(dbg_ack),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(int idx);
    if (idx <= 1)  return "R2";
    if (idx <= 9)  return "R3";
    if (idx == 10) return "R4";
    if (idx <= 12) return "R5";
    if (idx == 13) return "R6";
    if (idx == 14) return "R8";
    if (idx <= 16) return "R7";
    if (idx <= 21) return "R1";
    return "R11";
  endfunction

  // ---------------- reference model ----------------
  logic [31:0] mc [NM];
  int   pv [NM];
  bit   m_en, m_trk, m_clr, m_pre;
  int   m_thr, m_run;
  bit   m_dpv, m_dpw, m_dpf;
  int   m_dpb;

  function automatic logic [31:0] mread(int idx);
    if (idx < NM)  return mc[idx];
    if (idx == 20) return {30'd0, m_trk, m_en};
    if (idx == 21) return 32'(m_thr);
    return 32'd0;
  endfunction

  always begin
    @(posedge clk);
    begin
      int idx;
      logic [31:0] exp_w, exp_n;
      bit act, done, waitc;
      idx = int'(reg_addr[6:2]);
      if (rst) begin
        for (int i = 0; i < NM; i++) begin mc[i] = 0; pv[i] = 0; end
        m_en = 0; m_trk = 0; m_clr = 0; m_pre = 0; m_thr = 0; m_run = 0;
        m_dpv = 0; m_dpw = 0; m_dpf = 0; m_dpb = 0;
        exp_w = 0;
      end else begin
        exp_w = mread(idx);
        for (int i = 0; i < NM; i++) begin
          if (i == 14) mc[i] = mc[i] + 1;
          else if (m_clr) mc[i] = 0;
          else if (m_pre) mc[i] = 32'(i * 4);
          else mc[i] = mc[i] + 32'(pv[i]);
        end
        for (int i = 0; i < NM; i++) pv[i] = 0;
        act   = m_en && !(m_trk && dbg_ack);
        done  = m_dpv && hready && (hresp == 2'b00 || hresp == 2'b01);
        waitc = m_dpv && !hready && hresp == 2'b00;
        if (act) begin
          pv[0]  = (done && !m_dpw) ? 1 : 0;
          pv[1]  = (done && m_dpw) ? 1 : 0;
          if (done && m_dpf) pv[2 + m_dpb] = 1;
          pv[10] = waitc ? 1 : 0;
          pv[11] = (waitc && m_dpf && !ic_stall && hsel) ? 1 : 0;
          pv[12] = (waitc && m_dpf && ic_stall) ? 1 : 0;
          pv[13] = (waitc && m_run == m_thr) ? 1 : 0;
        end
        pv[15] = m_en ? 1 : 0;
        pv[16] = act ? 1 : 0;
        m_run = waitc ? m_run + 1 : 0;
        if (hready) begin
          m_dpv = htrans[1]; m_dpw = hwrite; m_dpf = (htrans == 2'b10); m_dpb = int'(hburst);
        end
        m_clr = reg_wen && idx == 22;
        m_pre = reg_wen && idx == 23;
        if (reg_wen && idx == 20) begin m_en = reg_wdata[0]; m_trk = reg_wdata[1]; end
        if (reg_wen && idx == 21) m_thr = int'(reg_wdata[15:0]);
      end
      exp_n = (idx < NM) ? (exp_w & 32'hFF) : exp_w;
      #1;
      // R11: every clock, read data equals the addressed value at the start of the cycle
      check(req_of(idx), rdata_w, exp_w);
      // R12: narrow counters hold the same values modulo 256
      check((idx < NM) ? "R12" : req_of(idx), rdata_n, exp_n);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_write(int idx, logic [31:0] d);
    reg_wen = 1'b1; reg_addr = 7'(idx * 4); reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic read_all();
    for (int i = 0; i < 24; i++) begin
      reg_addr = 7'(i * 4);
      tick();
    end
    reg_addr = 7'd0;
  endtask

  // one burst: first beat gets w0 waits (ic flag applies to them), later beats wn waits
  task automatic burst(bit wr, int bt, int beats, int w0, bit ic, int wn, logic [1:0] rsp0, bit sel);
    hwrite = wr; hburst = 3'(bt); hsel = sel;
    htrans = 2'b10; hready = 1'b1; hresp = 2'b00; tick();
    for (int i = 0; i < beats; i++) begin
      logic [1:0] nxt;
      int w;
      nxt = (i < beats - 1 && !(i == 0 && rsp0 != 2'b00)) ? 2'b11 : 2'b00;
      w = (i == 0) ? w0 : wn;
      for (int k = 0; k < w; k++) begin
        htrans = nxt; hready = 1'b0; hresp = 2'b00; ic_stall = (i == 0) ? ic : 1'b0; tick();
      end
      ic_stall = 1'b0;
      if (i == 0 && rsp0 != 2'b00) begin
        htrans = 2'b00; hready = 1'b0; hresp = rsp0; tick();
        hready = 1'b1; tick();
        hresp = 2'b00;
        break;
      end
      htrans = nxt; hready = 1'b1; hresp = 2'b00; tick();
    end
    htrans = 2'b00; hready = 1'b1; hresp = 2'b00; tick();
  endtask

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    // R1: reset state
    read_all();
    // R2 R3 with enable off: nothing counts (R7)
    burst(0, 0, 1, 0, 0, 0, 2'b00, 1);
    read_all();
    reg_write(20, 32'h1);
    reg_write(21, 32'd2);
    // R2 R3 R4 R5 R6 across burst types, causes and responses
    burst(0, 0, 1, 0, 0, 0, 2'b00, 1);
    burst(1, 3, 4, 2, 0, 1, 2'b00, 1);
    burst(0, 4, 8, 3, 1, 0, 2'b00, 1);
    burst(0, 1, 3, 4, 0, 2, 2'b00, 1);
    burst(1, 5, 8, 1, 0, 0, 2'b00, 0);
    burst(0, 2, 4, 0, 0, 3, 2'b00, 1);
    burst(1, 6, 16, 0, 0, 0, 2'b00, 1);
    burst(0, 7, 16, 5, 1, 1, 2'b00, 1);
    burst(1, 0, 1, 1, 0, 0, 2'b01, 1);
    burst(0, 3, 4, 1, 0, 0, 2'b10, 1);
    burst(1, 3, 4, 0, 0, 0, 2'b11, 1);
    read_all();
    // R6 with threshold zero
    reg_write(21, 32'd0);
    burst(0, 0, 1, 3, 0, 0, 2'b00, 1);
    read_all();
    // R7: debug freeze
    reg_write(20, 32'h3);
    dbg_ack = 1'b1;
    burst(0, 3, 4, 2, 0, 0, 2'b00, 1);
    dbg_ack = 1'b0;
    burst(1, 3, 4, 2, 0, 0, 2'b00, 1);
    read_all();
    // R9: clear landing in the middle of a wait run
    fork
      burst(0, 5, 8, 6, 1, 1, 2'b00, 1);
      begin repeat (4) tick(); reg_write(22, 32'h0); end
    join
    read_all();
    // R10: preset, then further counting on top
    reg_write(23, 32'h0);
    read_all();
    burst(0, 4, 8, 2, 0, 1, 2'b00, 1);
    read_all();
    // R7: enable off keeps event counters and enabled-cycle counter still
    reg_write(20, 32'h0);
    burst(1, 7, 16, 2, 0, 0, 2'b00, 1);
    read_all();
    // R8 R12: let the narrow total counter wrap
    repeat (300) tick();
    read_all();
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule